// File: doc/BRIEF.md
# Forced-Shutdown Holdoff Monitor

This block watches an active-low shutdown request that comes back from the secondary side of an isolated power converter. The secondary side has no power at first, so its supervisor cannot hold the line high yet. For that reason the request is masked for a holdoff window. The window starts when the controller's power-good state becomes active. Once the window has run out, a low level on the request raises a fault request. That fault request withdraws the power-good gate, and the surrounding sequencer uses it to turn off the power switch.

A mode input lets the same pin act as a second power-good enable. In that mode a low level simply closes the power-good gate, and no fault is ever raised. The holdoff length comes from a small table of power-of-two multiples of a base cycle count, picked by a select input. The pin is asynchronous and has no internal pull, so the board must drive it. It passes through a synchronizer before any decision is made.

Top module: `fsd_holdoff_mon`

## Requirements
- R1: While rst_n is low, fault_req and pg_gate are both 0, whatever the other inputs are.
- R2: The holdoff length is BASE_CYC << (STEP_SHIFT*k) cycles for hold_sel = k. With the defaults this gives 25, 50, 100 and 200 cycles. hold_sel is sampled only on clock edges where pwr_good is low. A change while pwr_good is high has no effect on the running window.
- R3: Fault mode is mode_sel = 0. In this mode, a low pin is ignored for the holdoff length L, counted from the first rising edge that samples pwr_good high (edge E0). If the pin is held low from before E0, fault_req is still 0 after edge E(L-1) and becomes 1 after edge E(L). A low pin that returns high before the window ends raises no fault.
- R4: In fault mode after the window, a pin that falls before edge A makes fault_req 1 and pg_gate 0 after edge A+2, and not before. Those three edges are the two synchronizer flops plus one output register.
- R5: Once raised, fault_req stays 1 for as long as pwr_good stays high, even if the pin returns high.
- R6: pwr_good sampled low clears fault_req and pg_gate after that edge. The next rise of pwr_good starts a fresh full-length window.
- R7: Enable mode is mode_sel = 1. In this mode pg_gate equals pwr_good AND the synchronized pin, with the same three-edge latency as R4, and fault_req is never raised.
- R8: In fault mode with no fault, pg_gate becomes 1 one edge after pwr_good is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shdn_n_pin | input | 1 | Asynchronous active-low shutdown request from the secondary side |
| pwr_good | input | 1 | Power-good state of the main sequencer, high when active |
| mode_sel | input | 1 | 0: pin is a fault source; 1: pin is a second power-good enable |
| hold_sel | input | SEL_W | Holdoff table index |
| fault_req | output | 1 | Fault request to the sequencer, high when active |
| pg_gate | output | 1 | Gated power-good, high when active |

## Verification
Each table vector is built from three inputs: the mode, the holdoff select and the pin level held across the whole window. The vectors separate a pin that should produce a fault from one masked by the enable mode, and a healthy pin from a stuck-low one. Directed tests pin down the exact edge at which the window closes. They also show that a low pulse inside the window is forgotten and that a late fall costs exactly three edges. Finally, they show that dropping power-good restarts the window and that a select change during the window is ignored.

// File: rtl/fsdh_pkg.sv
package fsdh_pkg;

   typedef enum logic {
      FSD_FAULT = 1'b0,
      FSD_PGEN  = 1'b1
   } fsd_mode_e;

   function automatic int unsigned fsdh_len(input int unsigned base,
                                            input int unsigned shift,
                                            input int unsigned idx);
      return base << (shift * idx);
   endfunction

endpackage

// File: rtl/fsdh_sync.sv
module fsdh_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= RST_VAL;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fsdh_window.sv
module fsdh_window
   import fsdh_pkg::*;
#(
   parameter int SEL_W      = 2,
   parameter int BASE_CYC   = 25,
   parameter int STEP_SHIFT = 1,
   parameter int CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_good,
   input  logic [SEL_W-1:0] hold_sel,
   output logic             expired
);

   localparam int NSEL = 1 << SEL_W;

   logic [CNT_W-1:0] len_tab [NSEL];
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W-1:0] cnt_q;
   logic             exp_q;

   generate
      for (genvar g = 0; g < NSEL; g++) begin : g_tab
         assign len_tab[g] = CNT_W'(fsdh_len(BASE_CYC, STEP_SHIFT, g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= len_tab[NSEL-1];
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (!pwr_good) begin
         lim_q <= len_tab[hold_sel];
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (!exp_q) begin
         if (cnt_q == lim_q - CNT_W'(1)) exp_q <= 1'b1;
         else                            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign expired = exp_q;

endmodule

// File: rtl/fsdh_decide.sv
module fsdh_decide
   import fsdh_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_good,
   input  logic      pin_s,
   input  fsd_mode_e mode,
   input  logic      expired,
   output logic      fault_req,
   output logic      pg_gate
);

   logic fault_q, pg_q;
   logic fault_nxt, pg_nxt, enable_ok;

   always_comb begin
      fault_nxt = pwr_good & (fault_q | ((mode == FSD_FAULT) & expired & ~pin_s));
      enable_ok = (mode == FSD_PGEN) ? pin_s : 1'b1;
      pg_nxt    = pwr_good & ~fault_nxt & enable_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         pg_q    <= 1'b0;
      end else begin
         fault_q <= fault_nxt;
         pg_q    <= pg_nxt;
      end
   end

   assign fault_req = fault_q;
   assign pg_gate   = pg_q;

endmodule

// File: rtl/fsd_holdoff_mon.sv
module fsd_holdoff_mon
   import fsdh_pkg::*;
#(
   parameter int SEL_W       = 2,
   parameter int BASE_CYC    = 25,
   parameter int STEP_SHIFT  = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shdn_n_pin,
   input  logic             pwr_good,
   input  logic             mode_sel,
   input  logic [SEL_W-1:0] hold_sel,
   output logic             fault_req,
   output logic             pg_gate
);

   localparam int NSEL    = 1 << SEL_W;
   localparam int MAX_LEN = BASE_CYC << (STEP_SHIFT * (NSEL - 1));
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BASE_CYC < 1) begin : g_bad_base
         $error("BASE_CYC must be at least 1");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("SEL_W must lie in 1..4");
      end
      if (MAX_LEN > 1000000) begin : g_bad_len
         $error("longest holdoff exceeds counter budget");
      end
   endgenerate

   logic pin_s;
   logic expired;

   fsdh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (shdn_n_pin),
      .q     (pin_s)
   );

   fsdh_window #(
      .SEL_W      (SEL_W),
      .BASE_CYC   (BASE_CYC),
      .STEP_SHIFT (STEP_SHIFT),
      .CNT_W      (CNT_W)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .hold_sel (hold_sel),
      .expired  (expired)
   );

   fsdh_decide u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_good  (pwr_good),
      .pin_s     (pin_s),
      .mode      (fsd_mode_e'(mode_sel)),
      .expired   (expired),
      .fault_req (fault_req),
      .pg_gate   (pg_gate)
   );

endmodule

// File: rtl/fsd_holdoff_mon_chk.sv
module fsd_holdoff_mon_chk #(
   parameter int BASE_CYC = 25
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_good,
   input logic mode_sel,
   input logic fault_req,
   input logic pg_gate
);

   logic [19:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_q <= '0;
      else if (!pwr_good)      run_q <= '0;
      else if (~&run_q)        run_q <= run_q + 20'd1;
   end

   // R6
   pg_low_clears_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !fault_req);

   // R6
   pg_low_clears_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !pg_gate);

   // R4
   fault_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_req |-> !pg_gate);

   // R5
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_req && pwr_good) |=> fault_req);

   // R7
   pgen_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_req && mode_sel) |=> !fault_req);

   // R3
   holdoff_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_req) |-> (run_q >= 20'(BASE_CYC)));

endmodule

bind fsd_holdoff_mon fsd_holdoff_mon_chk #(.BASE_CYC(BASE_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_good  (pwr_good),
   .mode_sel  (mode_sel),
   .fault_req (fault_req),
   .pg_gate   (pg_gate)
);

// File: tb/tb_fsd_holdoff_mon.sv
module tb_fsd_holdoff_mon;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shdn_n_pin = 1'b1;
   logic       pwr_good = 1'b0;
   logic       mode_sel = 1'b0;
   logic [1:0] hold_sel = 2'd0;
   logic       fault_req, pg_gate;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fsd_holdoff_mon dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .shdn_n_pin (shdn_n_pin),
      .pwr_good   (pwr_good),
      .mode_sel   (mode_sel),
      .hold_sel   (hold_sel),
      .fault_req  (fault_req),
      .pg_gate    (pg_gate)
   );

   // holdoff per R2: 25 << k cycles
   function automatic int hold_len(input int k);
      return 25 << k;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what,
                      input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // vector: {mode, sel[1:0], pin, exp_fault, exp_pg}
   localparam logic [5:0] VEC [6] = '{
      {1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
      {1'b0, 2'd1, 1'b1, 1'b0, 1'b1},
      {1'b0, 2'd3, 1'b0, 1'b1, 1'b0},
      {1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
      {1'b1, 2'd2, 1'b1, 1'b0, 1'b1},
      {1'b0, 2'd2, 1'b1, 1'b0, 1'b1}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state with power-good already high
      pwr_good = 1'b1;
      shdn_n_pin = 1'b0;
      tick(4);
      chk("R1", "fault_req in reset", fault_req, 1'b0);
      chk("R1", "pg_gate in reset", pg_gate, 1'b0);
      pwr_good = 1'b0;
      shdn_n_pin = 1'b1;
      rst_n = 1'b1;
      tick(3);

      // table walk: R3 / R7 / R8 main function
      for (int i = 0; i < 6; i++) begin
         pwr_good   = 1'b0;
         mode_sel   = VEC[i][5];
         hold_sel   = VEC[i][4:3];
         shdn_n_pin = VEC[i][2];
         tick(3);
         pwr_good = 1'b1;
         tick(hold_len(VEC[i][4:3]) + 3);
         chk(VEC[i][5] ? "R7" : "R3", $sformatf("vec%0d fault_req", i), fault_req, VEC[i][1]);
         chk(VEC[i][5] ? "R7" : "R8", $sformatf("vec%0d pg_gate", i), pg_gate, VEC[i][0]);
      end
      pwr_good = 1'b0;
      tick(2);

      // R3 exact window boundary, sel=1
      mode_sel = 1'b0; hold_sel = 2'd1; shdn_n_pin = 1'b0;
      tick(3);
      pwr_good = 1'b1;
      tick(hold_len(1));
      chk("R3", "fault before window end", fault_req, 1'b0);
      chk("R3", "pg before window end", pg_gate, 1'b1);
      tick(1);
      chk("R3", "fault at window end", fault_req, 1'b1);
      chk("R4", "pg dropped with fault", pg_gate, 1'b0);

      // R6 clear
      pwr_good = 1'b0;
      tick(1);
      chk("R6", "fault cleared", fault_req, 1'b0);
      chk("R6", "pg cleared", pg_gate, 1'b0);

      // R6 restart: fresh full window
      pwr_good = 1'b1;
      tick(hold_len(1));
      chk("R6", "restarted window masks pin", fault_req, 1'b0);
      tick(1);
      chk("R6", "fault after restarted window", fault_req, 1'b1);
      pwr_good = 1'b0;
      tick(2);

      // R2 select change during window ignored
      hold_sel = 2'd0;
      tick(2);
      pwr_good = 1'b1;
      tick(5);
      hold_sel = 2'd3;
      tick(hold_len(0) - 5);
      chk("R2", "fault before sel0 window end", fault_req, 1'b0);
      tick(1);
      chk("R2", "sel change ignored, sel0 length kept", fault_req, 1'b1);
      pwr_good = 1'b0;
      tick(2);

      // R3 low pulse inside window forgotten
      hold_sel = 2'd1; shdn_n_pin = 1'b0;
      tick(2);
      pwr_good = 1'b1;
      tick(10);
      shdn_n_pin = 1'b1;
      tick(hold_len(1) + 5);
      chk("R3", "low inside window ignored", fault_req, 1'b0);
      chk("R3", "pg kept after masked low", pg_gate, 1'b1);

      // R4 late fall latency
      shdn_n_pin = 1'b0;
      tick(2);
      chk("R4", "no fault after two edges", fault_req, 1'b0);
      chk("R4", "pg kept after two edges", pg_gate, 1'b1);
      tick(1);
      chk("R4", "fault on third edge", fault_req, 1'b1);
      chk("R4", "pg off on third edge", pg_gate, 1'b0);

      // R5 sticky
      shdn_n_pin = 1'b1;
      tick(5);
      chk("R5", "fault stays with pin high", fault_req, 1'b1);
      pwr_good = 1'b0;
      tick(2);

      // R7 enable mode
      mode_sel = 1'b1; hold_sel = 2'd0; shdn_n_pin = 1'b1;
      tick(2);
      pwr_good = 1'b1;
      tick(hold_len(0) + 5);
      chk("R7", "pg with pin high", pg_gate, 1'b1);
      shdn_n_pin = 1'b0;
      tick(2);
      chk("R7", "pg before third edge", pg_gate, 1'b1);
      tick(1);
      chk("R7", "pg off on third edge", pg_gate, 1'b0);
      tick(5);
      chk("R7", "no fault in enable mode", fault_req, 1'b0);
      shdn_n_pin = 1'b1;
      tick(3);
      chk("R7", "pg back with pin high", pg_gate, 1'b1);
      pwr_good = 1'b0;
      tick(2);

      // R8 one-edge power-good gate latency
      mode_sel = 1'b0;
      tick(2);
      pwr_good = 1'b1;
      tick(1);
      chk("R8", "pg one edge after power-good", pg_gate, 1'b1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule